// File: doc/BRIEF.md
# Node Supervisor with Watchdog and Status LEDs

This block supervises one compute node. It accepts decoded strobes from a control-bus receiver and a byte-wide software reset register. From these it drives an active-low node reset line and two active-low front-panel lamps, one green and one yellow. Bus transport and message parsing happen upstream, so the block only sees two kinds of command. A status message carries a 3-bit state code. A reset command carries a broadcast flag and a 12-bit target slot.

Every reset is a pulse of fixed length. When the pulse ends, a watchdog loads from a programmed delay. Each accepted status message reloads it. If the watchdog runs out, the block pulses a report strobe and latches the node as dead until the next reset.

A seven-state machine tracks the node: held in reset, waiting, booting, testing, normal, limp-along and dead. The lamps show this state as steady or flashing patterns. The flash rate comes from a free-running prescaler. The programmed delay should be far longer than the 200 µs bus-busy timeout of the control bus.

Top module: `node_supervisor`

## Requirements
- R1: After system reset, and after every accepted reset trigger, `nodeResetN` is low for exactly `RST_CYCLES` clock cycles. Both lamps are dark (both outputs high) for the whole pulse.
- R2: A reset command takes effect in the cycle it is presented if `cmdGlobal` is 1 or `cmdSlot` equals `ownSlot`. Any other reset command has no effect.
- R3: A reset trigger that arrives while the pulse is running neither restarts nor lengthens the pulse.
- R4: A write to the software reset register with bit 0 equal to 0 starts a reset pulse one cycle after the write. Bits 7:1 are ignored, so a write with bit 0 equal to 1 has no effect.
- R5: The software reset register returns to its inactive value during the pulse, so no further pulse follows unless there is a new write.
- R6: Between the end of the pulse and the first accepted status message, the node is waiting: yellow flashes and green is dark.
- R7: Status codes map to lamp patterns as follows. Codes 0 (booting) and 1 (testing) give green flashing and yellow dark. Code 2 (normal) gives green only. Code 3 (limp) gives both lit. Code 4 (dead) gives yellow only. Codes 5 to 7 are ignored.
- R8: The watchdog loads `wdDelay` when the pulse ends and on each accepted status message. If no further message arrives, `wdTimeout` rises `wdDelay`+1 cycles after the last load.
- R9: `wdTimeout` is high for exactly one cycle. After it, and after a code-4 message, the node shows yellow only and ignores status messages until the next reset.
- R10: A lamp is lit when its output is low. A flashing lamp holds each level for exactly `FLASH_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| ownSlot | input | SLOT_W | Slot identity of this node |
| statusValid | input | 1 | One-cycle strobe for a status message |
| statusCode | input | 3 | State code carried by the status message |
| cmdValid | input | 1 | One-cycle strobe for a reset command |
| cmdGlobal | input | 1 | Reset command addressed to every node |
| cmdSlot | input | SLOT_W | Target slot of the reset command |
| swWrite | input | 1 | Write strobe for the software reset register |
| swData | input | 8 | Write data for the software reset register |
| wdDelay | input | WD_W | Programmed watchdog reload value in cycles |
| nodeResetN | output | 1 | Active-low node reset |
| ledGreenN | output | 1 | Active-low green lamp drive |
| ledYellowN | output | 1 | Active-low yellow lamp drive |
| wdTimeout | output | 1 | One-cycle watchdog expiry report |

## Verification
The bench builds the block with `RST_CYCLES`=6, `FLASH_DIV`=3 and `WD_W`=12, and drives `wdDelay` at 40. At these values a reset pulse, a full flash period and a complete watchdog run each take only a few dozen cycles. The bench can therefore count pulse widths, flash half-periods and timeout latency to the exact cycle. It can also reach the dead state by expiry several times within a short run, and check that it stays latched.

// File: rtl/nodesup_pkg.sv
package nodesup_pkg;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_WAIT = 3'd1,
    ST_BOOT = 3'd2,
    ST_TEST = 3'd3,
    ST_RUN  = 3'd4,
    ST_LIMP = 3'd5,
    ST_DEAD = 3'd6
  } nodeState_t;

  localparam logic [2:0] CODE_BOOT = 3'd0;
  localparam logic [2:0] CODE_TEST = 3'd1;
  localparam logic [2:0] CODE_RUN  = 3'd2;
  localparam logic [2:0] CODE_LIMP = 3'd3;
  localparam logic [2:0] CODE_DEAD = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic holdLoad;
    logic holdRun;
    logic wdLoad;
    logic wdRun;
    logic swClear;
  } dpStrobe_t;

endpackage

// File: rtl/nodesup_dp.sv
module nodesup_dp
  import nodesup_pkg::*;
#(
  parameter int SLOT_W     = 12,
  parameter int WD_W       = 32,
  parameter int RST_CYCLES = 5000000,
  parameter int FLASH_DIV  = 12500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] ownSlot,
  input  logic              cmdValid,
  input  logic              cmdGlobal,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              swWrite,
  input  logic [7:0]        swData,
  input  logic [WD_W-1:0]   wdDelay,
  input  dpStrobe_t         strobe,
  output logic              resetReq,
  output logic              holdDone,
  output logic              wdZero,
  output logic              flashPhase
);

  localparam int HOLD_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES + 1) : 1;
  localparam int DIV_W  = (FLASH_DIV > 1) ? $clog2(FLASH_DIV + 1) : 1;
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(RST_CYCLES - 1);
  localparam logic [DIV_W-1:0]  DIV_MAX  = DIV_W'(FLASH_DIV - 1);

  logic              swBit;
  logic              cmdHit;
  logic              swUpperUnused;
  logic [HOLD_W-1:0] holdCnt;
  logic [WD_W-1:0]   wdCnt;
  logic [DIV_W-1:0]  divCnt;

  // upper register bits carry no function
  assign swUpperUnused = ^swData[7:1];

  // software reset register bit 0, inactive high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               swBit <= 1'b1;
    else if (strobe.swClear) swBit <= 1'b1;
    else if (swWrite)        swBit <= swData[0];
  end

  assign cmdHit   = cmdValid && (cmdGlobal || (cmdSlot == ownSlot));
  assign resetReq = cmdHit || !swBit;

  // reset pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                holdCnt <= HOLD_MAX;
    else if (strobe.holdLoad)                 holdCnt <= HOLD_MAX;
    else if (strobe.holdRun && holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end
  assign holdDone = (holdCnt == '0);

  // watchdog down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wdCnt <= '0;
    else if (strobe.wdLoad)               wdCnt <= wdDelay;
    else if (strobe.wdRun && wdCnt != '0) wdCnt <= wdCnt - 1'b1;
  end
  assign wdZero = (wdCnt == '0);

  // free-running flash prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      flashPhase <= 1'b0;
    end else if (divCnt == DIV_MAX) begin
      divCnt     <= '0;
      flashPhase <= !flashPhase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R8
  wd_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wdLoad |=> wdCnt == $past(wdDelay));

  // R5
  sw_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swClear |=> swBit);

  // R10
  flash_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(flashPhase) |-> $past(divCnt) == DIV_MAX);

  // R3
  hold_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdRun && !strobe.holdLoad && !holdDone) |=> holdCnt == $past(holdCnt) - 1'b1);

endmodule

// File: rtl/nodesup_ctrl.sv
module nodesup_ctrl
  import nodesup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       statusValid,
  input  logic [2:0] statusCode,
  input  logic       resetReq,
  input  logic       holdDone,
  input  logic       wdZero,
  input  logic       flashPhase,
  output dpStrobe_t  strobe,
  output logic       nodeResetN,
  output logic       ledGreenN,
  output logic       ledYellowN,
  output logic       wdTimeout
);

  nodeState_t state, nextState;
  logic       live, codeOk, msgTake, expire;

  function automatic nodeState_t codeToState(input logic [2:0] code);
    case (code)
      CODE_BOOT: codeToState = ST_BOOT;
      CODE_TEST: codeToState = ST_TEST;
      CODE_RUN:  codeToState = ST_RUN;
      CODE_LIMP: codeToState = ST_LIMP;
      default:   codeToState = ST_DEAD;
    endcase
  endfunction

  assign live    = (state inside {ST_WAIT, ST_BOOT, ST_TEST, ST_RUN, ST_LIMP});
  assign codeOk  = (statusCode <= CODE_DEAD);
  assign msgTake = live && statusValid && codeOk;

  always_comb begin
    nextState      = state;
    strobe         = '0;
    expire         = 1'b0;
    strobe.holdRun = (state == ST_HOLD);
    strobe.swClear = (state == ST_HOLD);
    strobe.wdRun   = live;
    if (state != ST_HOLD && resetReq) begin
      nextState       = ST_HOLD;
      strobe.holdLoad = 1'b1;
    end else begin
      case (state)
        ST_HOLD: begin
          if (holdDone) begin
            nextState     = ST_WAIT;
            strobe.wdLoad = 1'b1;
          end
        end
        ST_DEAD: nextState = ST_DEAD;
        default: begin
          if (msgTake) begin
            strobe.wdLoad = 1'b1;
            nextState     = codeToState(statusCode);
          end else if (wdZero) begin
            nextState = ST_DEAD;
            expire    = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      wdTimeout <= 1'b0;
    end else begin
      state     <= nextState;
      wdTimeout <= expire;
    end
  end

  assign nodeResetN = (state != ST_HOLD);

  // lamp encoding, low = lit
  always_comb begin
    case (state)
      ST_WAIT:          begin ledGreenN = 1'b1;        ledYellowN = !flashPhase; end
      ST_BOOT, ST_TEST: begin ledGreenN = !flashPhase; ledYellowN = 1'b1;        end
      ST_RUN:           begin ledGreenN = 1'b0;        ledYellowN = 1'b1;        end
      ST_LIMP:          begin ledGreenN = 1'b0;        ledYellowN = 1'b0;        end
      ST_DEAD:          begin ledGreenN = 1'b1;        ledYellowN = 1'b0;        end
      default:          begin ledGreenN = 1'b1;        ledYellowN = 1'b1;        end
    endcase
  end

  // R1
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !holdDone) |=> state == ST_HOLD);

  // R1
  leds_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nodeResetN |-> (ledGreenN && ledYellowN));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |=> !wdTimeout);

  // R9
  timeout_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |-> state == ST_DEAD);

  // R9
  dead_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEAD && !resetReq) |=> state == ST_DEAD);

endmodule

// File: rtl/node_supervisor.sv
module node_supervisor
  import nodesup_pkg::*;
#(
  parameter int SLOT_W     = 12,
  parameter int WD_W       = 32,
  parameter int RST_CYCLES = 5000000,
  parameter int FLASH_DIV  = 12500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] ownSlot,
  input  logic              statusValid,
  input  logic [2:0]        statusCode,
  input  logic              cmdValid,
  input  logic              cmdGlobal,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              swWrite,
  input  logic [7:0]        swData,
  input  logic [WD_W-1:0]   wdDelay,
  output logic              nodeResetN,
  output logic              ledGreenN,
  output logic              ledYellowN,
  output logic              wdTimeout
);

  dpStrobe_t strobe;
  logic      resetReq, holdDone, wdZero, flashPhase;

  nodesup_dp #(
    .SLOT_W    (SLOT_W),
    .WD_W      (WD_W),
    .RST_CYCLES(RST_CYCLES),
    .FLASH_DIV (FLASH_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ownSlot   (ownSlot),
    .cmdValid  (cmdValid),
    .cmdGlobal (cmdGlobal),
    .cmdSlot   (cmdSlot),
    .swWrite   (swWrite),
    .swData    (swData),
    .wdDelay   (wdDelay),
    .strobe    (strobe),
    .resetReq  (resetReq),
    .holdDone  (holdDone),
    .wdZero    (wdZero),
    .flashPhase(flashPhase)
  );

  nodesup_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .statusValid(statusValid),
    .statusCode (statusCode),
    .resetReq   (resetReq),
    .holdDone   (holdDone),
    .wdZero     (wdZero),
    .flashPhase (flashPhase),
    .strobe     (strobe),
    .nodeResetN (nodeResetN),
    .ledGreenN  (ledGreenN),
    .ledYellowN (ledYellowN),
    .wdTimeout  (wdTimeout)
  );

endmodule

// File: tb/sim_node_supervisor.sv
`timescale 1ns/1ps
module sim_node_supervisor;

  localparam int SLOT_W = 12;
  localparam int WD_W   = 12;
  localparam int RSTC   = 6;
  localparam int FDIV   = 3;
  localparam int DELAY  = 40;
  localparam logic [SLOT_W-1:0] MYSLOT = 12'h5A3;

  // lamp modes: 0 dark, 1 lit, 2 flashing
  localparam int NVEC = 7;
  localparam logic [2:0] VEC_CODE [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd2, 3'd4};
  localparam int         VEC_G    [NVEC] = '{2, 2, 1, 1, 1, 1, 0};
  localparam int         VEC_Y    [NVEC] = '{0, 0, 0, 1, 1, 0, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic statusValid = 1'b0;
  logic [2:0] statusCode = '0;
  logic cmdValid = 1'b0;
  logic cmdGlobal = 1'b0;
  logic [SLOT_W-1:0] cmdSlot = '0;
  logic swWrite = 1'b0;
  logic [7:0] swData = 8'hFF;
  logic [WD_W-1:0] wdDelay = WD_W'(DELAY);
  logic nodeResetN, ledGreenN, ledYellowN, wdTimeout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = !clk;

  node_supervisor #(
    .SLOT_W(SLOT_W), .WD_W(WD_W), .RST_CYCLES(RSTC), .FLASH_DIV(FDIV)
  ) u0 (
    .clk(clk), .rstN(rstN), .ownSlot(MYSLOT),
    .statusValid(statusValid), .statusCode(statusCode),
    .cmdValid(cmdValid), .cmdGlobal(cmdGlobal), .cmdSlot(cmdSlot),
    .swWrite(swWrite), .swData(swData), .wdDelay(wdDelay),
    .nodeResetN(nodeResetN), .ledGreenN(ledGreenN),
    .ledYellowN(ledYellowN), .wdTimeout(wdTimeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendStatus(input logic [2:0] code);
    @(negedge clk); statusValid = 1'b1; statusCode = code;
    @(negedge clk); statusValid = 1'b0;
  endtask

  task automatic sendCmd(input logic glob, input logic [SLOT_W-1:0] slot);
    @(negedge clk); cmdValid = 1'b1; cmdGlobal = glob; cmdSlot = slot;
    @(negedge clk); cmdValid = 1'b0; cmdGlobal = 1'b0;
  endtask

  task automatic writeSw(input logic [7:0] d);
    @(negedge clk); swWrite = 1'b1; swData = d;
    @(negedge clk); swWrite = 1'b0; swData = 8'hFF;
  endtask

  // counts low samples of nodeResetN, starting at the current negedge
  task automatic measureLow(output int w);
    w = 0;
    for (int i = 0; i < 20 && nodeResetN; i++) @(negedge clk);
    while (!nodeResetN) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic countLow(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!nodeResetN) lows++;
    end
  endtask

  task automatic checkLeds(input string tag, input int gExp, input int yExp);
    bit g0 = 0, g1 = 0, y0 = 0, y1 = 0;
    int gObs, yObs;
    for (int i = 0; i < 2 * FDIV + 2; i++) begin
      @(negedge clk);
      if (ledGreenN) g1 = 1; else g0 = 1;
      if (ledYellowN) y1 = 1; else y0 = 1;
    end
    gObs = (g0 && g1) ? 2 : (g0 ? 1 : 0);
    yObs = (y0 && y1) ? 2 : (y0 ? 1 : 0);
    chk({tag, " green"}, gObs, gExp);
    chk({tag, " yellow"}, yObs, yExp);
  endtask

  // cycles until wdTimeout is seen, counted from the current negedge
  task automatic cyclesToTimeout(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      if (wdTimeout) break;
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int w, n, strobes;
    logic prevY;

    // reset state (R1)
    repeat (3) @(negedge clk);
    chk("R1 reset nodeResetN", nodeResetN, 0);
    chk("R1 reset green dark", ledGreenN, 1);
    chk("R1 reset yellow dark", ledYellowN, 1);
    chk("R1 reset no timeout", wdTimeout, 0);
    rstN = 1'b1;
    measureLow(w);
    chk("R1 power-on pulse width", w, RSTC);

    // waiting state (R6) and flash half-period (R10)
    checkLeds("R6 waiting", 0, 2);
    prevY = ledYellowN;
    for (int i = 0; i < 10 && ledYellowN == prevY; i++) @(negedge clk);
    prevY = ledYellowN;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n++;
      if (ledYellowN != prevY) break;
    end
    chk("R10 flash half-period", n, FDIV);

    // status code table (R7, R9)
    for (int v = 0; v < NVEC; v++) begin
      sendStatus(VEC_CODE[v]);
      checkLeds($sformatf("R7 code %0d", VEC_CODE[v]), VEC_G[v], VEC_Y[v]);
    end

    // dead is latched (R9)
    sendStatus(3'd2);
    checkLeds("R9 dead ignores normal code", 0, 1);

    // slot qualification (R2)
    sendCmd(1'b0, MYSLOT ^ 12'h001);
    countLow(10, w);
    chk("R2 other slot ignored", w, 0);
    sendCmd(1'b0, MYSLOT);
    measureLow(w);
    chk("R2 own slot pulse", w, RSTC);
    sendCmd(1'b1, 12'h000);
    measureLow(w);
    chk("R2 global pulse", w, RSTC);

    // trigger during pulse (R3)
    sendCmd(1'b0, MYSLOT);
    fork
      measureLow(w);
      begin
        repeat (2) @(negedge clk);
        cmdValid = 1'b1; cmdGlobal = 1'b1;
        @(negedge clk);
        cmdValid = 1'b0; cmdGlobal = 1'b0;
      end
    join
    chk("R3 pulse not extended", w, RSTC);

    // software register (R4, R5, R8)
    writeSw(8'h01);
    countLow(8, w);
    chk("R4 bit0 one ignored", w, 0);
    writeSw(8'hFF);
    countLow(8, w);
    chk("R4 upper bits ignored", w, 0);
    writeSw(8'hFE);
    measureLow(w);
    chk("R4 software pulse", w, RSTC);
    cyclesToTimeout(n);
    chk("R8 timeout after release", n, DELAY + 1);
    @(negedge clk);
    chk("R9 strobe one cycle", wdTimeout, 0);
    checkLeds("R9 dead after expiry", 0, 1);
    countLow(3 * RSTC, w);
    chk("R5 no repeat pulse", w, 0);

    // keepalive then expiry (R8)
    sendCmd(1'b1, MYSLOT);
    measureLow(w);
    chk("R1 pulse before keepalive", w, RSTC);
    strobes = 0;
    for (int k = 0; k < 5; k++) begin
      sendStatus(3'd2);
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (wdTimeout) strobes++;
      end
    end
    chk("R8 keepalive no timeout", strobes, 0);
    checkLeds("R7 normal after keepalive", 1, 0);
    sendStatus(3'd2);
    cyclesToTimeout(n);
    chk("R8 timeout after last message", n, DELAY + 1);

    finishRun();
  end

endmodule